// File: doc/BRIEF.md
# Converter Serial Control Port

This block is the digital control port of a four-channel delta-sigma converter, as a microcontroller sees it. The link has four wires: an active-low chip select, a serial clock, a data input and a data output. The port takes 8-bit command bytes, MSB first. Each byte is either a register access or a request to run a conversion or a calibration. The port holds the converter's 32-bit offset, gain, configuration and channel-setup registers, and it shifts words out MSB first.

The serial clock, the chip select and the data input are each passed through a synchronizer into the system clock domain. Data input is taken on the rising serial-clock edge. Data output changes on the falling edge.

When a conversion or calibration is requested, the port emits a one-cycle start pulse that carries the selected setup entry. It then holds the data output high until the `res_valid` input reports a result, and drops the data output low to signal completion.

- A conversion result is read back after 8 clear clocks.
- A calibration result is written into the offset or gain register of the channel named by the setup entry.

Top module: `adc_ctl_port`

## Requirements
- R1: After reset every register reads as zero, the data output is low and no start pulse is given.
- R2: A command byte with bit 7 = 0 is a register access with these fields:
  - bit 6: access all
  - bits 5:4: register index
  - bit 3: direction, 1 = read and 0 = write
  - bits 2:0: register select, where 001 = offset, 010 = gain, 011 = configuration and 101 = channel setup

  A write loads the next 32 bits, MSB first. A read returns the register on the next 32 clocks: each bit is valid before its rising edge, and the first one follows the falling edge after the command byte.
- R3: With bit 6 = 1, an offset, gain or setup access covers indexes 0 to 3 in order, as four consecutive 32-bit words.
- R4: A register access whose select code is 000, 100, 110 or 111 is ignored. The port stays in command mode, the data output stays low and no register changes.
- R5: A command byte with bit 7 = 1 and bits 2:0 = 000 requests a conversion. Bits 5:3 pick setup entry k. Entry k is the upper half (bits 31:16) of setup register k>>1 when k is even, and the lower half when k is odd. The port pulses `op_start` for one cycle with `op_cal` = 0 and `op_setup` = entry k, and the data output stays high while the operation is busy.
- R6: After `res_valid`, the data output goes low. The next 8 clocks are ignored, and the following 32 clocks return the result MSB first. The port then returns to command mode.
- R7: Bits 2:0 = 001 request an offset calibration and 010 request a gain calibration. Each gives `op_start` with `op_cal` = 1. On `res_valid`, the result is written to the offset or gain register of the channel in entry bits 15:14. The data output goes low and the port returns to command mode.
- R8: Command bytes received while an operation is busy are ignored.
- R9: Raising chip select during a partial transfer discards it and returns the port to command mode.
- R10: Operation codes 011 to 111 are ignored and give no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_mosi | input | 1 | Serial data into the port |
| spi_miso | output | 1 | Serial data out; high while busy, low when done |
| res_valid | input | 1 | One-cycle strobe: result of the running operation is ready |
| res_data | input | 32 | Result word that goes with `res_valid` |
| op_start | output | 1 | One-cycle pulse requesting a conversion or calibration |
| op_cal | output | 1 | 1 when the request is a calibration |
| op_setup | output | 16 | Selected channel-setup entry |

## Verification
The serial clock edges reach the control logic two or three system cycles after they occur at the pin, and the data output settles one cycle later. The bench therefore holds each serial-clock phase for 8 system cycles and samples the data output at the end of the low phase, just before it raises the clock. The start pulse comes during the high phase of the eighth clock of a byte. A one-cycle monitor catches it, and the bench checks the captured setup entry after the byte. The done flag is due two cycles after `res_valid`, so the bench samples it 4 cycles later. Register contents are checked only by reading them back through the serial port, against a bench-side model of all thirteen words.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  localparam int unsigned CMD_W = 8;

  localparam logic [2:0] SEL_OFFS  = 3'b001;
  localparam logic [2:0] SEL_GAIN  = 3'b010;
  localparam logic [2:0] SEL_CONF  = 3'b011;
  localparam logic [2:0] SEL_SETUP = 3'b101;

  localparam logic [2:0] OP_CONV = 3'b000;
  localparam logic [2:0] OP_OCAL = 3'b001;
  localparam logic [2:0] OP_GCAL = 3'b010;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_BUSY,
    ST_CLR,
    ST_RES
  } port_state_t;

  function automatic logic sel_known(input logic [2:0] s);
    return (s == SEL_OFFS) || (s == SEL_GAIN) || (s == SEL_CONF) || (s == SEL_SETUP);
  endfunction

  function automatic logic sel_indexed(input logic [2:0] s);
    return (s == SEL_OFFS) || (s == SEL_GAIN) || (s == SEL_SETUP);
  endfunction

endpackage

// File: rtl/adc_spi_sync.sv
module adc_spi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_in,
  input  logic sclk_in,
  input  logic mosi_in,
  output logic cs_n_s,
  output logic mosi_s,
  output logic sclk_rise,
  output logic sclk_fall
);

  logic [STAGES-1:0] cs_pipe;
  logic [STAGES-1:0] ck_pipe;
  logic [STAGES-1:0] di_pipe;
  logic              ck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_pipe <= '1;
      ck_pipe <= '0;
      di_pipe <= '0;
      ck_last <= 1'b0;
    end else begin
      cs_pipe <= {cs_pipe[STAGES-2:0], cs_n_in};
      ck_pipe <= {ck_pipe[STAGES-2:0], sclk_in};
      di_pipe <= {di_pipe[STAGES-2:0], mosi_in};
      ck_last <= ck_pipe[STAGES-1];
    end
  end

  assign cs_n_s    = cs_pipe[STAGES-1];
  assign mosi_s    = di_pipe[STAGES-1];
  assign sclk_rise = ck_pipe[STAGES-1] & ~ck_last;
  assign sclk_fall = ~ck_pipe[STAGES-1] & ck_last;

endmodule

// File: rtl/adc_reg_bank.sv
module adc_reg_bank
  import adc_ctl_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NCH    = 4,
  localparam int unsigned PTR_W = $clog2(NCH),
  localparam int unsigned ENT_W = PTR_W + 1,
  localparam int unsigned HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [2:0]        rd_sel,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  input  logic [ENT_W-1:0]  ent_idx,
  output logic [HALF_W-1:0] ent_data
);

  logic [WORD_W-1:0] offs_q  [NCH];
  logic [WORD_W-1:0] gain_q  [NCH];
  logic [WORD_W-1:0] setup_q [NCH];
  logic [WORD_W-1:0] conf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        offs_q[i]  <= '0;
        gain_q[i]  <= '0;
        setup_q[i] <= '0;
      end
      conf_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_OFFS:  offs_q[wr_idx]  <= wr_data;
        SEL_GAIN:  gain_q[wr_idx]  <= wr_data;
        SEL_SETUP: setup_q[wr_idx] <= wr_data;
        SEL_CONF:  conf_q          <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_OFFS:  rd_data = offs_q[rd_idx];
      SEL_GAIN:  rd_data = gain_q[rd_idx];
      SEL_SETUP: rd_data = setup_q[rd_idx];
      SEL_CONF:  rd_data = conf_q;
      default:   rd_data = '0;
    endcase
  end

  logic [WORD_W-1:0] ent_word;
  assign ent_word = setup_q[ent_idx[ENT_W-1:1]];
  assign ent_data = ent_idx[0] ? ent_word[HALF_W-1:0] : ent_word[WORD_W-1:HALF_W];

endmodule

// File: rtl/adc_port_fsm.sv
module adc_port_fsm
  import adc_ctl_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NCH    = 4,
  localparam int unsigned PTR_W = $clog2(NCH),
  localparam int unsigned ENT_W = PTR_W + 1,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              res_valid,
  input  logic [WORD_W-1:0] res_data,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [HALF_W-1:0] ent_data,
  output logic [2:0]        rd_sel,
  output logic [PTR_W-1:0]  rd_idx,
  output logic [ENT_W-1:0]  ent_idx,
  output logic              wr_en,
  output logic [2:0]        wr_sel,
  output logic [PTR_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data,
  output logic              miso,
  output logic              op_start,
  output logic              op_cal,
  output logic [HALF_W-1:0] op_setup,
  output logic              busy
);

  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [PTR_W-1:0] IDX_LAST  = PTR_W'(NCH - 1);

  port_state_t       state_q;
  logic [WORD_W-1:0] in_sr;
  logic [WORD_W-1:0] out_sr;
  logic [WORD_W-1:0] res_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        sel_q;
  logic [PTR_W-1:0]  word_q;
  logic [PTR_W-1:0]  end_q;
  logic              cal_q;
  logic [2:0]        cal_sel_q;
  logic [PTR_W-1:0]  cal_idx_q;

  logic [CMD_W-1:0]  byte_w;
  logic              all_w;
  logic [PTR_W-1:0]  first_w;
  logic [WORD_W-1:0] word_w;

  assign byte_w  = {in_sr[CMD_W-2:0], mosi_s};
  assign word_w  = {in_sr[WORD_W-2:0], mosi_s};
  assign all_w   = byte_w[6] & sel_indexed(byte_w[2:0]);
  assign first_w = all_w ? '0 : byte_w[5:4];

  assign rd_sel  = (state_q == ST_CMD) ? byte_w[2:0] : sel_q;
  assign rd_idx  = (state_q == ST_CMD) ? first_w : word_q + PTR_W'(1);
  assign ent_idx = byte_w[5:3];
  assign busy    = (state_q == ST_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_CMD;
      in_sr     <= '0;
      out_sr    <= '0;
      res_q     <= '0;
      cnt_q     <= '0;
      sel_q     <= '0;
      word_q    <= '0;
      end_q     <= '0;
      cal_q     <= 1'b0;
      cal_sel_q <= '0;
      cal_idx_q <= '0;
      wr_en     <= 1'b0;
      wr_sel    <= '0;
      wr_idx    <= '0;
      wr_data   <= '0;
      miso      <= 1'b0;
      op_start  <= 1'b0;
      op_cal    <= 1'b0;
      op_setup  <= '0;
    end else begin
      op_start <= 1'b0;
      wr_en    <= 1'b0;

      if (state_q == ST_BUSY) begin
        if (res_valid) begin
          cnt_q <= '0;
          if (cal_q) begin
            wr_en   <= 1'b1;
            wr_sel  <= cal_sel_q;
            wr_idx  <= cal_idx_q;
            wr_data <= res_data;
            state_q <= ST_CMD;
          end else begin
            res_q   <= res_data;
            state_q <= ST_CLR;
          end
        end
      end else if (cs_n_s) begin
        state_q <= ST_CMD;
        cnt_q   <= '0;
      end else if (sclk_rise) begin
        case (state_q)
          ST_CMD: begin
            in_sr <= word_w;
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == BYTE_LAST) begin
              cnt_q <= '0;
              if (!byte_w[CMD_W-1]) begin
                if (sel_known(byte_w[2:0])) begin
                  sel_q  <= byte_w[2:0];
                  word_q <= first_w;
                  end_q  <= all_w ? IDX_LAST : first_w;
                  if (byte_w[3]) begin
                    out_sr  <= rd_data;
                    state_q <= ST_RD;
                  end else begin
                    state_q <= ST_WR;
                  end
                end
              end else if (byte_w[2:0] == OP_CONV || byte_w[2:0] == OP_OCAL ||
                           byte_w[2:0] == OP_GCAL) begin
                op_start  <= 1'b1;
                op_cal    <= (byte_w[2:0] != OP_CONV);
                op_setup  <= ent_data;
                cal_q     <= (byte_w[2:0] != OP_CONV);
                cal_sel_q <= (byte_w[2:0] == OP_OCAL) ? SEL_OFFS : SEL_GAIN;
                cal_idx_q <= ent_data[HALF_W-1 -: PTR_W];
                state_q   <= ST_BUSY;
              end
            end
          end
          ST_WR: begin
            in_sr <= word_w;
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == WORD_LAST) begin
              cnt_q   <= '0;
              wr_en   <= 1'b1;
              wr_sel  <= sel_q;
              wr_idx  <= word_q;
              wr_data <= word_w;
              if (word_q == end_q) state_q <= ST_CMD;
              else                 word_q  <= word_q + PTR_W'(1);
            end
          end
          ST_RD: begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == WORD_LAST) begin
              cnt_q <= '0;
              if (word_q == end_q) begin
                state_q <= ST_CMD;
              end else begin
                word_q <= word_q + PTR_W'(1);
                out_sr <= rd_data;
              end
            end
          end
          ST_CLR: begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == BYTE_LAST) begin
              cnt_q   <= '0;
              out_sr  <= res_q;
              state_q <= ST_RES;
            end
          end
          ST_RES: begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == WORD_LAST) begin
              cnt_q   <= '0;
              state_q <= ST_CMD;
            end
          end
          default: state_q <= ST_CMD;
        endcase
      end else if (sclk_fall && (state_q == ST_RD || state_q == ST_RES)) begin
        out_sr <= {out_sr[WORD_W-2:0], 1'b0};
      end

      if (state_q == ST_BUSY) begin
        miso <= 1'b1;
      end else if (state_q != ST_RD && state_q != ST_RES) begin
        miso <= 1'b0;
      end else if (sclk_fall) begin
        miso <= out_sr[WORD_W-1];
      end
    end
  end

endmodule

// File: rtl/adc_ctl_port.sv
module adc_ctl_port #(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned NCH         = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PTR_W  = $clog2(NCH),
  localparam int unsigned ENT_W  = PTR_W + 1,
  localparam int unsigned HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              res_valid,
  input  logic [WORD_W-1:0] res_data,
  output logic              op_start,
  output logic              op_cal,
  output logic [HALF_W-1:0] op_setup
);

  logic              cs_n_s, mosi_s, sclk_rise, sclk_fall;
  logic [2:0]        rd_sel, wr_sel;
  logic [PTR_W-1:0]  rd_idx, wr_idx;
  logic [ENT_W-1:0]  ent_idx;
  logic [WORD_W-1:0] rd_data, wr_data;
  logic [HALF_W-1:0] ent_data;
  logic              wr_en;
  logic              fsm_busy;

  adc_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .cs_n_in(spi_cs_n), .sclk_in(spi_sclk), .mosi_in(spi_mosi),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  adc_port_fsm #(.WORD_W(WORD_W), .NCH(NCH)) u_fsm (
    .clk(clk), .rst(rst),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .res_valid(res_valid), .res_data(res_data),
    .rd_data(rd_data), .ent_data(ent_data),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .ent_idx(ent_idx),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
    .miso(spi_miso), .op_start(op_start), .op_cal(op_cal), .op_setup(op_setup),
    .busy(fsm_busy)
  );

  adc_reg_bank #(.WORD_W(WORD_W), .NCH(NCH)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .ent_idx(ent_idx), .ent_data(ent_data)
  );

endmodule

// File: rtl/adc_ctl_port_chk.sv
module adc_ctl_port_chk (
  input logic clk,
  input logic rst,
  input logic op_start,
  input logic busy,
  input logic res_valid,
  input logic spi_miso
);

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start);

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    op_start |-> busy);

  // R5
  busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> spi_miso);

  // R8
  busy_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !op_start);

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && res_valid) |=> !busy);

endmodule

bind adc_ctl_port adc_ctl_port_chk u_chk (
  .clk(clk), .rst(rst), .op_start(op_start), .busy(fsm_busy),
  .res_valid(res_valid), .spi_miso(spi_miso)
);

// File: tb/adc_ctl_port_tb.sv
module adc_ctl_port_tb_top;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic spi_miso;
  logic res_valid = 1'b0;
  logic [31:0] res_data = '0;
  logic op_start, op_cal;
  logic [15:0] op_setup;

  always #5 clk = ~clk;

  adc_ctl_port dut_i (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .res_valid(res_valid),
    .res_data(res_data), .op_start(op_start), .op_cal(op_cal), .op_setup(op_setup)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] m_offs [4];
  logic [31:0] m_gain [4];
  logic [31:0] m_setup [4];
  logic [31:0] m_conf;

  int n_start = 0;
  logic [15:0] cap_setup = '0;
  logic cap_cal = 1'b0;

  always @(negedge clk) begin
    if (op_start) begin
      n_start++;
      cap_setup = op_setup;
      cap_cal = op_cal;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high();
    spi_sclk = 1'b0;
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    r = spi_miso;
    spi_sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
  endtask

  task automatic xfer_word(input logic [31:0] w, output logic [31:0] r);
    logic s;
    for (int i = 31; i >= 0; i--) begin
      bit_x(w[i], s);
      r[i] = s;
    end
  endtask

  function automatic logic [7:0] reg_cmd(input logic all, input logic [1:0] idx,
                                         input logic rd, input logic [2:0] sel);
    return {1'b0, all, idx, rd, sel};
  endfunction

  function automatic logic [7:0] op_cmd(input logic [2:0] ent, input logic [2:0] code);
    return {1'b1, 1'b0, ent, code};
  endfunction

  function automatic logic [31:0] model_rd(input logic [2:0] sel, input logic [1:0] idx);
    case (sel)
      3'b001:  return m_offs[idx];
      3'b010:  return m_gain[idx];
      3'b101:  return m_setup[idx];
      3'b011:  return m_conf;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] model_ent(input logic [2:0] k);
    return k[0] ? m_setup[k[2:1]][15:0] : m_setup[k[2:1]][31:16];
  endfunction

  task automatic do_write(input logic [2:0] sel, input logic [1:0] idx, input logic [31:0] d);
    logic [31:0] r;
    cs_low();
    send_byte(reg_cmd(1'b0, idx, 1'b0, sel));
    xfer_word(d, r);
    cs_high();
    case (sel)
      3'b001: m_offs[idx] = d;
      3'b010: m_gain[idx] = d;
      3'b101: m_setup[idx] = d;
      3'b011: m_conf = d;
      default: ;
    endcase
  endtask

  task automatic do_read(input string req, input logic [2:0] sel, input logic [1:0] idx);
    logic [31:0] r;
    cs_low();
    send_byte(reg_cmd(1'b0, idx, 1'b1, sel));
    xfer_word(32'h0, r);
    cs_high();
    chk(req, r, model_rd(sel, idx));
  endtask

  task automatic pulse_result(input logic [31:0] d);
    res_data = d;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] d;
    logic [2:0] sel;
    logic [1:0] idx;
    int n0;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4; i++) begin
      m_offs[i] = '0; m_gain[i] = '0; m_setup[i] = '0;
    end
    m_conf = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk("R1 miso", {31'h0, spi_miso}, 32'h0);
    chk("R1 start", n_start, 0);
    do_read("R1 conf", 3'b011, 2'd0);
    do_read("R1 gain", 3'b010, 2'd2);
    do_read("R1 setup", 3'b101, 2'd3);

    // R2: directed corners then random register traffic
    do_write(3'b011, 2'd0, 32'h8008_0000);
    do_read("R2 conf", 3'b011, 2'd0);
    do_write(3'b001, 2'd3, 32'hFFFF_FFFF);
    do_read("R2 offs3", 3'b001, 2'd3);
    for (int t = 0; t < 24; t++) begin
      case ($urandom % 4)
        0: sel = 3'b001;
        1: sel = 3'b010;
        2: sel = 3'b011;
        default: sel = 3'b101;
      endcase
      idx = 2'($urandom);
      if ($urandom % 2) do_write(sel, idx, $urandom);
      else do_read("R2 rand", sel, idx);
    end

    // R3: access-all write and read of the gain registers
    cs_low();
    send_byte(reg_cmd(1'b1, 2'd2, 1'b0, 3'b010));
    for (int i = 0; i < 4; i++) begin
      d = 32'hA5000000 | (i * 32'h01010101) ^ $urandom;
      xfer_word(d, r);
      m_gain[i] = d;
    end
    cs_high();
    cs_low();
    send_byte(reg_cmd(1'b1, 2'd1, 1'b1, 3'b010));
    for (int i = 0; i < 4; i++) begin
      xfer_word(32'h0, r);
      chk("R3 gain all", r, m_gain[i]);
    end
    cs_high();

    // R4: unused select code on a read returns nothing
    cs_low();
    send_byte(reg_cmd(1'b0, 2'd1, 1'b1, 3'b100));
    xfer_word(32'h0, r);
    cs_high();
    chk("R4 no data", r, 32'h0);
    do_read("R4 conf kept", 3'b011, 2'd0);

    // R9: aborted partial write
    cs_low();
    send_byte(reg_cmd(1'b0, 2'd0, 1'b0, 3'b011));
    for (int i = 0; i < 16; i++) bit_x(1'b1, r[0]);
    cs_high();
    do_read("R9 conf kept", 3'b011, 2'd0);

    // setup entries for operations
    do_write(3'b101, 2'd1, 32'h4123_C456);
    do_write(3'b101, 2'd2, 32'h8A5A_0000);

    // R5/R6/R8: conversion on entry 3, write attempt while busy
    n0 = n_start;
    cs_low();
    send_byte(op_cmd(3'd3, 3'b000));
    chk("R5 start", n_start, n0 + 1);
    chk("R5 cal", {31'h0, cap_cal}, 32'h0);
    chk("R5 entry", {16'h0, cap_setup}, {16'h0, model_ent(3'd3)});
    send_byte(reg_cmd(1'b0, 2'd0, 1'b0, 3'b011));
    xfer_word(32'h1234_5678, r);
    chk("R5 busy flag", {31'h0, spi_miso}, 32'h1);
    pulse_result(32'hC0FF_EE01);
    chk("R6 done", {31'h0, spi_miso}, 32'h0);
    send_byte(8'h00);
    xfer_word(32'h0, r);
    chk("R6 result", r, 32'hC0FF_EE01);
    cs_high();
    do_read("R8 conf kept", 3'b011, 2'd0);

    // R5: even entry selects the upper half
    n0 = n_start;
    cs_low();
    send_byte(op_cmd(3'd4, 3'b000));
    chk("R5 entry even", {16'h0, cap_setup}, {16'h0, model_ent(3'd4)});
    chk("R5 start2", n_start, n0 + 1);
    pulse_result(32'h0000_0001);
    send_byte(8'h00);
    xfer_word(32'h0, r);
    cs_high();
    chk("R6 result2", r, 32'h0000_0001);

    // R7: offset calibration via entry 3 (channel 3), gain calibration via entry 2 (channel 1)
    cs_low();
    send_byte(op_cmd(3'd3, 3'b001));
    chk("R7 cal flag", {31'h0, cap_cal}, 32'h1);
    pulse_result(32'h0BAD_F00D);
    chk("R7 done", {31'h0, spi_miso}, 32'h0);
    m_offs[model_ent(3'd3)[15:14]] = 32'h0BAD_F00D;
    send_byte(reg_cmd(1'b0, 2'd3, 1'b1, 3'b001));
    xfer_word(32'h0, r);
    cs_high();
    chk("R7 offs written", r, m_offs[3]);
    cs_low();
    send_byte(op_cmd(3'd2, 3'b010));
    pulse_result(32'h7654_3210);
    cs_high();
    m_gain[model_ent(3'd2)[15:14]] = 32'h7654_3210;
    do_read("R7 gain written", 3'b010, 2'd1);
    do_read("R7 gain other", 3'b010, 2'd0);

    // R10: unused operation codes
    n0 = n_start;
    cs_low();
    send_byte(op_cmd(3'd1, 3'b011));
    send_byte(op_cmd(3'd5, 3'b111));
    repeat (4) @(negedge clk);
    chk("R10 no start", n_start, n0);
    chk("R10 miso", {31'h0, spi_miso}, 32'h0);
    cs_high();
    do_read("R10 conf", 3'b011, 2'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule